// File: doc/BRIEF.md
# Motor Bridge Protection Supervisor

This block supervises the power stage of a pair of full bridges from digitized sensor readings. Each accepted sample carries a supply-voltage word, a die-temperature word and two high-side switch current words per bridge. From these it derives a global power-good level with hysteresis, a thermal-shutdown state with hysteresis, and an overcurrent condition per bridge. The overcurrent condition is judged on the sum of that bridge's two high-side currents.

For each bridge, a raw fault (that bridge's overcurrent, or thermal shutdown) passes through an assert-delay and release-delay filter. The filtered result drives an active-low fault output, modelled on an open-drain pin. The filtered fault also holds the bridge enable low. Once the fault clears, a programmable disable window keeps the bridge off before it retries. A fault that returns during the window restarts the window.

Thresholds and timing values are loaded through a simple register write port. Samples arrive on a valid/ready stream. The block never applies back-pressure: ready is high whenever reset is released, and a sample is taken on every clock edge where valid and ready are both high.

Top module: `mdrv_guard`

## Requirements
- R1: `pwr_good` is 0 after reset. On an accepted sample it sets when the supply word is at least the turn-on level (register 0, default 700). It clears when the supply word is below the turn-off level (register 1, default 600). Otherwise it holds. It updates at the edge that accepts the sample.
- R2: Thermal shutdown engages on a sample with temperature at or above the trip level (register 2, default 165). It releases on a sample with temperature at or below trip minus hysteresis (register 3, default 15). While it is engaged, the raw fault of every bridge is set.
- R3: A bridge's raw overcurrent is set on an accepted sample when the sum of its two current words is at least its threshold. Bridge b's threshold is in register 8+b. The raw overcurrent holds until the next sample.
- R4: A threshold register holding 0 selects the maximum threshold `OC_MAX` (default 560).
- R5: `flt_n[b]` falls at the edge that is on-delay+1 edges after the edge that set the raw fault, provided the raw fault stays set throughout. The on-delay is register 4. A raw fault that clears earlier never reaches `flt_n`.
- R6: A set fault releases (`flt_n[b]` rises) off-delay+1 edges after the raw fault clears. The off-delay is register 5.
- R7: After `flt_n[b]` rises, `bridge_en[b]` stays low for dis+1 further edges. The disable time dis is register 6. If the fault returns, the window restarts from zero after that fault releases.
- R8: `bridge_en[b]` is high exactly when `drv_en_req[b]`, `pwr_good`, `flt_n[b]` are all high and no disable window is running.
- R9: `smp_ready` equals the released reset. Sample words presented with `smp_valid` low change no state.
- R10: A register write (`cfg_we`, `cfg_addr`, `cfg_data`) takes effect for the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high out of reset) |
| smp_vsup | input | VW | Supply voltage word |
| smp_temp | input | TW | Die temperature word |
| smp_cur | input | NB*2*IW | High-side current words [bridge][switch] |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_data | input | CW | Register write data |
| drv_en_req | input | NB | Requested bridge enables |
| bridge_en | output | NB | Gated bridge enables |
| flt_n | output | NB | Active-low fault per bridge |
| pwr_good | output | 1 | Supply above lockout (hysteresis) |

## Verification
The assertions assume that the turn-on supply level is above the turn-off level, and that the thermal hysteresis is smaller than the trip level. They also assume that `drv_en_req` does not change in a way that races the fault checks. The bench keeps the threshold registers ordered that way, and holds the enable requests constant while gating is checked. Random supply words are drawn around the two lockout levels, with temperature and currents held benign, so that only the hysteresis path is exercised there. The fault timing is checked with directed samples spaced so that each window completes.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  localparam int ADDR_W = 4;
  typedef enum logic [ADDR_W-1:0] {
    CA_UV_ON   = 4'd0,
    CA_UV_OFF  = 4'd1,
    CA_TRIP    = 4'd2,
    CA_HYST    = 4'd3,
    CA_ON_DLY  = 4'd4,
    CA_OFF_DLY = 4'd5,
    CA_DIS     = 4'd6,
    CA_OC_BASE = 4'd8
  } cfg_addr_e;
endpackage

// File: rtl/mdg_hyst.sv
module mdg_hyst #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] val,
  input  logic [W-1:0] set_lvl,
  input  logic [W-1:0] clr_lvl,
  output logic         state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= 1'b0;
    else if (upd) begin
      if (!state && val >= set_lvl) state <= 1'b1;
      else if (state && val < clr_lvl) state <= 1'b0;
    end
  end
endmodule

// File: rtl/mdg_cfg.sv
module mdg_cfg
  import mdg_pkg::*;
#(
  parameter int NB = 2,
  parameter int VW = 12,
  parameter int TW = 12,
  parameter int IW = 12,
  parameter int CW = 16,
  parameter int UV_ON_RST = 700,
  parameter int UV_OFF_RST = 600,
  parameter int TRIP_RST = 165,
  parameter int HYST_RST = 15,
  parameter int ON_DLY_RST = 20,
  parameter int OFF_DLY_RST = 10,
  parameter int DIS_RST = 20000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CW-1:0]           data,
  output logic [VW-1:0]           uv_on,
  output logic [VW-1:0]           uv_off,
  output logic [TW-1:0]           trip,
  output logic [TW-1:0]           hyst,
  output logic [CW-1:0]           on_dly,
  output logic [CW-1:0]           off_dly,
  output logic [CW-1:0]           dis_time,
  output logic [NB-1:0][IW:0]     oc_thr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_on    <= VW'(UV_ON_RST);
      uv_off   <= VW'(UV_OFF_RST);
      trip     <= TW'(TRIP_RST);
      hyst     <= TW'(HYST_RST);
      on_dly   <= CW'(ON_DLY_RST);
      off_dly  <= CW'(OFF_DLY_RST);
      dis_time <= CW'(DIS_RST);
    end else if (we) begin
      case (addr)
        CA_UV_ON:   uv_on    <= data[VW-1:0];
        CA_UV_OFF:  uv_off   <= data[VW-1:0];
        CA_TRIP:    trip     <= data[TW-1:0];
        CA_HYST:    hyst     <= data[TW-1:0];
        CA_ON_DLY:  on_dly   <= data;
        CA_OFF_DLY: off_dly  <= data;
        CA_DIS:     dis_time <= data;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oc_thr[b] <= '0;
      else if (we && addr == ADDR_W'(CA_OC_BASE + b)) oc_thr[b] <= data[IW:0];
    end
  end
endmodule

// File: rtl/mdg_bridge.sv
module mdg_bridge #(
  parameter int IW = 12,
  parameter int CW = 16,
  parameter int OC_MAX = 560
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [1:0][IW-1:0] cur,
  input  logic [IW:0]        thr,
  input  logic               hot,
  input  logic               pg,
  input  logic               en_req,
  input  logic [CW-1:0]      on_dly,
  input  logic [CW-1:0]      off_dly,
  input  logic [CW-1:0]      dis_time,
  output logic               raw,
  output logic               flt,
  output logic               en
);
  logic [IW:0]   sum, eff_thr;
  logic          oc_q, blocked;
  logic [CW-1:0] fcnt, dcnt;

  assign sum     = {1'b0, cur[0]} + {1'b0, cur[1]};
  assign eff_thr = (thr == '0) ? (IW+1)'(OC_MAX) : thr;
  assign raw     = oc_q | hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else if (fire) oc_q <= (sum >= eff_thr);
  end

  // assert / release delay filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt  <= 1'b0;
      fcnt <= '0;
    end else if (flt != raw) begin
      if (fcnt >= (flt ? off_dly : on_dly)) begin
        flt  <= raw;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
    end else fcnt <= '0;
  end

  // disable window after a fault releases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b0;
      dcnt    <= '0;
    end else if (flt) begin
      blocked <= 1'b1;
      dcnt    <= '0;
    end else if (blocked) begin
      if (dcnt >= dis_time) blocked <= 1'b0;
      else dcnt <= dcnt + 1'b1;
    end
  end

  assign en = en_req & pg & ~flt & ~blocked;
endmodule

// File: rtl/mdrv_guard.sv
module mdrv_guard
  import mdg_pkg::*;
#(
  parameter int NB = 2,
  parameter int VW = 12,
  parameter int TW = 12,
  parameter int IW = 12,
  parameter int CW = 16,
  parameter int OC_MAX = 560
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic [VW-1:0]            smp_vsup,
  input  logic [TW-1:0]            smp_temp,
  input  logic [NB-1:0][1:0][IW-1:0] smp_cur,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CW-1:0]            cfg_data,
  input  logic [NB-1:0]            drv_en_req,
  output logic [NB-1:0]            bridge_en,
  output logic [NB-1:0]            flt_n,
  output logic                     pwr_good
);
  logic [VW-1:0]      uv_on, uv_off;
  logic [TW-1:0]      trip, hyst;
  logic [CW-1:0]      on_dly, off_dly, dis_time;
  logic [NB-1:0][IW:0] oc_thr;
  logic [TW:0]        t_clr;
  logic               fire, hot;
  logic [NB-1:0]      raw_fault, flt;

  assign smp_ready = rst_n;
  assign fire      = smp_valid & smp_ready;
  // release when temp <= trip - hyst, i.e. temp < trip - hyst + 1
  assign t_clr = (trip >= hyst) ? ({1'b0, trip} - {1'b0, hyst} + 1'b1) : (TW+1)'(1);

  mdg_cfg #(.NB(NB), .VW(VW), .TW(TW), .IW(IW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .uv_on(uv_on), .uv_off(uv_off), .trip(trip), .hyst(hyst),
    .on_dly(on_dly), .off_dly(off_dly), .dis_time(dis_time), .oc_thr(oc_thr)
  );

  mdg_hyst #(.W(VW)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .upd(fire), .val(smp_vsup),
    .set_lvl(uv_on), .clr_lvl(uv_off), .state(pwr_good)
  );

  mdg_hyst #(.W(TW+1)) u_therm (
    .clk(clk), .rst_n(rst_n), .upd(fire), .val({1'b0, smp_temp}),
    .set_lvl({1'b0, trip}), .clr_lvl(t_clr), .state(hot)
  );

  for (genvar b = 0; b < NB; b++) begin : g_br
    mdg_bridge #(.IW(IW), .CW(CW), .OC_MAX(OC_MAX)) u_br (
      .clk(clk), .rst_n(rst_n), .fire(fire), .cur(smp_cur[b]), .thr(oc_thr[b]),
      .hot(hot), .pg(pwr_good), .en_req(drv_en_req[b]),
      .on_dly(on_dly), .off_dly(off_dly), .dis_time(dis_time),
      .raw(raw_fault[b]), .flt(flt[b]), .en(bridge_en[b])
    );
  end

  assign flt_n = ~flt;
endmodule

// File: rtl/mdg_checker.sv
module mdg_checker #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          pwr_good,
  input logic [NB-1:0] drv_en_req,
  input logic [NB-1:0] bridge_en,
  input logic [NB-1:0] flt_n,
  input logic [NB-1:0] raw_fault
);
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

  assert_pg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> $stable(pwr_good));

  for (genvar b = 0; b < NB; b++) begin : g_b
    assert_en_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bridge_en[b] |-> (drv_en_req[b] && pwr_good && flt_n[b]));

    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_n[b]) |-> $past(raw_fault[b]));

    assert_window_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_n[b]) |-> !bridge_en[b]);
  end
endmodule

bind mdrv_guard mdg_checker #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .pwr_good(pwr_good), .drv_en_req(drv_en_req), .bridge_en(bridge_en),
  .flt_n(flt_n), .raw_fault(raw_fault)
);

// File: tb/mdrv_guard_test.sv
module mdrv_guard_test;
  localparam int NB = 2, VW = 12, TW = 12, IW = 12, CW = 16;
  localparam int ON_D = 3, OFF_D = 2, DIS_D = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready;
  logic [VW-1:0] smp_vsup = '0;
  logic [TW-1:0] smp_temp = '0;
  logic [NB-1:0][1:0][IW-1:0] smp_cur = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [NB-1:0] drv_en_req = '0, bridge_en, flt_n;
  logic pwr_good;
  int checks = 0, failures = 0;
  bit done = 0, pg_m = 0;

  always #5 clk = ~clk;

  mdrv_guard uut (.*);

  function automatic bit next_pg(bit pg, int v);
    if (!pg && v >= 700) return 1'b1;
    if (pg && v < 600) return 1'b0;
    return pg;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = CW'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(int v, int t, int a1, int a2, int b1, int b2);
    @(negedge clk);
    smp_valid = 1'b1; smp_vsup = VW'(v); smp_temp = TW'(t);
    smp_cur[0][0] = IW'(a1); smp_cur[0][1] = IW'(a2);
    smp_cur[1][0] = IW'(b1); smp_cur[1][1] = IW'(b2);
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic idle_junk(int v);
    @(negedge clk);
    smp_vsup = VW'(v);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7153));
    #1;
    chk("R9 ready in reset", smp_ready, 0);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset pwr_good", pwr_good, 0);
    chk("R5 reset flt_n", flt_n, 3);
    chk("R8 reset bridge_en", bridge_en, 0);
    chk("R9 ready", smp_ready, 1);

    wr(4, ON_D); wr(5, OFF_D); wr(6, DIS_D);

    // R1 directed hysteresis
    send(699, 20, 0, 0, 0, 0); chk("R1 below on", pwr_good, 0);
    idle_junk(900);            chk("R9 invalid ignored", pwr_good, 0);
    send(700, 20, 0, 0, 0, 0); chk("R1 at on", pwr_good, 1);
    send(600, 20, 0, 0, 0, 0); chk("R1 at off holds", pwr_good, 1);
    send(599, 20, 0, 0, 0, 0); chk("R1 below off", pwr_good, 0);
    send(650, 20, 0, 0, 0, 0); chk("R1 mid holds low", pwr_good, 0);

    // R1 / R9 constrained random
    pg_m = 0;
    for (int i = 0; i < 300; i++) begin
      int v;
      v = 550 + int'($urandom % 201);
      if ($urandom % 4 == 0) begin
        idle_junk(v);
        chk("R9 random idle", pwr_good, pg_m);
      end else begin
        send(v, 20, 0, 0, 0, 0);
        pg_m = next_pg(pg_m, v);
        chk("R1 random", pwr_good, pg_m);
      end
    end

    send(800, 20, 0, 0, 0, 0);
    drv_en_req = 2'b11;
    tick(1);
    chk("R8 enabled", bridge_en, 3);

    // R10 / R3 threshold write and sum compare
    wr(8, 300);
    send(800, 20, 150, 149, 0, 0);
    tick(ON_D + 3);
    chk("R3 sum below thr", flt_n, 3);
    chk("R10 write effective", bridge_en, 3);
    send(800, 20, 150, 150, 0, 0);
    tick(ON_D);
    chk("R5 before on-delay", flt_n, 3);
    tick(1);
    chk("R5 after on-delay", flt_n, 2);
    chk("R8 faulted bridge off", bridge_en, 2);
    send(800, 20, 0, 0, 0, 0);
    tick(OFF_D);
    chk("R6 before off-delay", flt_n, 2);
    tick(1);
    chk("R6 after off-delay", flt_n, 3);
    tick(DIS_D);
    chk("R7 window end-1", bridge_en, 2);
    tick(1);
    chk("R7 window over", bridge_en, 3);

    // R7 restart
    send(800, 20, 200, 200, 0, 0); tick(ON_D + 1);
    chk("R3 fault again", flt_n, 2);
    send(800, 20, 0, 0, 0, 0); tick(OFF_D + 1);
    chk("R6 release again", flt_n, 3);
    tick(4);
    send(800, 20, 200, 200, 0, 0); tick(ON_D + 1);
    chk("R7 refault in window", flt_n, 2);
    send(800, 20, 0, 0, 0, 0); tick(OFF_D + 1);
    tick(DIS_D);
    chk("R7 restarted window", bridge_en, 2);
    tick(1);
    chk("R7 restarted window end", bridge_en, 3);

    // R5 short glitch filtered
    send(800, 20, 400, 400, 0, 0);
    send(800, 20, 0, 0, 0, 0);
    tick(8);
    chk("R5 glitch filtered", flt_n, 3);
    chk("R5 glitch en", bridge_en, 3);

    // R4 zero threshold -> 560
    wr(9, 0);
    send(800, 20, 0, 0, 280, 279); tick(ON_D + 3);
    chk("R4 below max", flt_n, 3);
    send(800, 20, 0, 0, 280, 280); tick(ON_D + 1);
    chk("R4 at max", flt_n, 1);
    send(800, 20, 0, 0, 0, 0); tick(OFF_D + 1 + DIS_D + 1);
    chk("R4 recovered", bridge_en, 3);

    // R2 thermal
    send(800, 164, 0, 0, 0, 0); tick(ON_D + 3);
    chk("R2 below trip", flt_n, 3);
    send(800, 165, 0, 0, 0, 0); tick(ON_D + 1);
    chk("R2 trip both", flt_n, 0);
    chk("R2 both disabled", bridge_en, 0);
    send(800, 151, 0, 0, 0, 0); tick(OFF_D + 4);
    chk("R2 inside hysteresis", flt_n, 0);
    send(800, 150, 0, 0, 0, 0); tick(OFF_D + 1);
    chk("R2 released", flt_n, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule